// File: doc/BRIEF.md
# Terminal Address Capture and Parity Qualifier

This block holds the 5-bit bus address and the address parity bit of a MIL-STD-1553 remote terminal, and reports whether that pair is fit for answering non-broadcast commands. The pair can come from dedicated address pins or from the host data bus. A source-select configuration bit picks between the two.

When the pins are the source, a latch strobe input sets how the held value follows them. With the strobe low, the held value tracks the pins. A low-to-high strobe transition captures the pins and freezes them. With the strobe held high, a capture happens only after a short host sequence: set an enhanced-mode bit, set an arm bit, then write the capture register. The strobe is sampled through a synchronizer, so every capture is a clocked event. When the host bus is the source, the pins and the strobe are ignored. The capture-register write then loads the address from data bits 5..1 and the parity from data bit 0.

The response-enable output is high when the held address and parity together contain an odd number of ones. Broadcast handling does not use it.

Top module: `rt_addr_capture`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and par_o is 1. All configuration bits are cleared, so the pins are the source after reset.
- R2: With the pin source selected and the synchronized strobe low, addr_o/par_o follow addr_pin_i/par_pin_i on every clock.
- R3: With the pin source selected, a low-to-high strobe transition captures the pin values. Later pin changes do not alter the held value while the strobe stays high.
- R4: Host register selects are: 3 = enhanced mode (bit 15), 4 = arm (bit 3), 5 = capture, 6 = source select (bit 5, 1 = host bus). A write stores the named bit of the data word. A capture-register write with both enhanced mode and arm set performs a capture.
- R5: A capture-register write while enhanced mode or arm is clear leaves addr_o/par_o unchanged.
- R6: With the host source selected, a capture loads addr_o from wr_data_i[5:1] (bit 5 is the MSB) and par_o from wr_data_i[0]. The pins and the strobe have no effect.
- R7: With the pin source selected and the strobe high, a host capture loads the pin values, and the data bits 5..0 of that write are ignored.
- R8: resp_ok_o is 1 exactly when {addr_o, par_o} holds an odd number of ones.
- R9: The strobe passes a two-stage synchronizer. A rising edge is recognised only after the strobe has been seen low, so a strobe tied high through reset makes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_pin_i | input | 5 | Address from pins |
| par_pin_i | input | 1 | Address parity from pin |
| strobe_i | input | 1 | Latch strobe, asynchronous |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 3 | Host register select |
| wr_data_i | input | 16 | Host write data |
| addr_o | output | 5 | Held terminal address |
| par_o | output | 1 | Held address parity |
| resp_ok_o | output | 1 | Odd parity: non-broadcast responses allowed |

## Verification
The assertions assume two things. First, the pins and the host data are stable at the clock edge on which a capture fires. Second, each host write lasts one clock with its select and data valid in that cycle. The bench drives every input on the falling edge and holds the pins steady for several cycles around each strobe transition, so the synchronizer never sees a pin change at the moment of capture. Host sweeps cover all 64 values of the low six data bits and every incomplete enable combination.

// File: rtl/rt_addr_capture_pkg.sv
package rt_addr_capture_pkg;
  localparam int unsigned DEF_ADDR_W = 5;
  localparam int unsigned DEF_SEL_W  = 3;
  localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/rtac_strobe_sync.sv
module rtac_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // reset high: a strobe tied high never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rtac_cfg_regs.sv
module rtac_cfg_regs #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned REG_ENH = 3,
  parameter int unsigned REG_ARM = 4,
  parameter int unsigned REG_CAP = 5,
  parameter int unsigned REG_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             enh_bit_i,
  input  logic             arm_bit_i,
  input  logic             src_bit_i,
  output logic             enh_o,
  output logic             arm_o,
  output logic             src_o,
  output logic             cap_fire_o
);
  logic enh_q, arm_q, src_q;
  logic sel_enh, sel_arm, sel_cap, sel_src;

  assign sel_enh = wr_en_i && (wr_sel_i == SEL_W'(REG_ENH));
  assign sel_arm = wr_en_i && (wr_sel_i == SEL_W'(REG_ARM));
  assign sel_cap = wr_en_i && (wr_sel_i == SEL_W'(REG_CAP));
  assign sel_src = wr_en_i && (wr_sel_i == SEL_W'(REG_SRC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enh_q <= 1'b0;
      arm_q <= 1'b0;
      src_q <= 1'b0;
    end else begin
      if (sel_enh) enh_q <= enh_bit_i;
      if (sel_arm) arm_q <= arm_bit_i;
      if (sel_src) src_q <= src_bit_i;
    end
  end

  assign enh_o      = enh_q;
  assign arm_o      = arm_q;
  assign src_o      = src_q;
  assign cap_fire_o = sel_cap & enh_q & arm_q;
endmodule

// File: rtl/rtac_addr_hold.sv
module rtac_addr_hold #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_host_i,
  input  logic              strb_lvl_i,
  input  logic              strb_rise_i,
  input  logic              cap_fire_i,
  input  logic [ADDR_W-1:0] addr_pin_i,
  input  logic              par_pin_i,
  input  logic [ADDR_W:0]   host_bits_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              par_o
);
  logic [ADDR_W:0] held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (src_host_i) begin
      if (cap_fire_i) held_d = host_bits_i;
    end else if (!strb_lvl_i || strb_rise_i || cap_fire_i) begin
      held_d = {addr_pin_i, par_pin_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= {{ADDR_W{1'b0}}, 1'b1};
    else         held_q <= held_d;
  end

  assign addr_o = held_q[ADDR_W:1];
  assign par_o  = held_q[0];
endmodule

// File: rtl/rtac_parity_gate.sv
module rtac_parity_gate #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              par_i,
  output logic              ok_o
);
  assign ok_o = ^{addr_i, par_i};
endmodule

// File: rtl/rt_addr_capture.sv
module rt_addr_capture
  import rt_addr_capture_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned SEL_W   = DEF_SEL_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned STAGES  = 2,
  parameter int unsigned REG_ENH = 3,
  parameter int unsigned BIT_ENH = 15,
  parameter int unsigned REG_ARM = 4,
  parameter int unsigned BIT_ARM = 3,
  parameter int unsigned REG_CAP = 5,
  parameter int unsigned REG_SRC = 6,
  parameter int unsigned BIT_SRC = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_pin_i,
  input  logic              par_pin_i,
  input  logic              strobe_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              par_o,
  output logic              resp_ok_o
);
  logic strb_lvl, strb_rise;
  logic enh_on, arm_on, src_sel, cap_fire;
  logic unused_data;

  assign unused_data = ^wr_data_i;

  rtac_strobe_sync #(.STAGES(STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .lvl_o   (strb_lvl),
    .rise_o  (strb_rise)
  );

  rtac_cfg_regs #(
    .SEL_W(SEL_W), .REG_ENH(REG_ENH), .REG_ARM(REG_ARM),
    .REG_CAP(REG_CAP), .REG_SRC(REG_SRC)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .enh_bit_i (wr_data_i[BIT_ENH]),
    .arm_bit_i (wr_data_i[BIT_ARM]),
    .src_bit_i (wr_data_i[BIT_SRC]),
    .enh_o     (enh_on),
    .arm_o     (arm_on),
    .src_o     (src_sel),
    .cap_fire_o(cap_fire)
  );

  rtac_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_host_i (src_sel),
    .strb_lvl_i (strb_lvl),
    .strb_rise_i(strb_rise),
    .cap_fire_i (cap_fire),
    .addr_pin_i (addr_pin_i),
    .par_pin_i  (par_pin_i),
    .host_bits_i(wr_data_i[ADDR_W:0]),
    .addr_o     (addr_o),
    .par_o      (par_o)
  );

  rtac_parity_gate #(.ADDR_W(ADDR_W)) u_par (
    .addr_i(addr_o),
    .par_i (par_o),
    .ok_o  (resp_ok_o)
  );
endmodule

// File: rtl/rt_addr_capture_chk.sv
module rt_addr_capture_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_pin_i,
  input logic              par_pin_i,
  input logic [ADDR_W:0]   host_bits,
  input logic [ADDR_W-1:0] addr_o,
  input logic              par_o,
  input logic              src_sel,
  input logic              strb_lvl,
  input logic              strb_rise,
  input logic              cap_fire
);
  logic pin_cause, any_cause;
  assign pin_cause = !src_sel && (!strb_lvl || strb_rise || cap_fire);
  assign any_cause = pin_cause || (src_sel && cap_fire);

  AST_TRANSPARENT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_sel && !strb_lvl) |=> ({addr_o, par_o} == $past({addr_pin_i, par_pin_i}))); // R2

  AST_HOLD_WITHOUT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_cause |=> $stable({addr_o, par_o})); // R5

  AST_HOST_SOURCE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel && cap_fire) |=> ({addr_o, par_o} == $past(host_bits))); // R6

  AST_PIN_CAPTURE_ON_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_sel && strb_lvl && cap_fire) |=> ({addr_o, par_o} == $past({addr_pin_i, par_pin_i}))); // R7
endmodule

bind rt_addr_capture rt_addr_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_pin_i(addr_pin_i),
  .par_pin_i (par_pin_i),
  .host_bits (wr_data_i[ADDR_W:0]),
  .addr_o    (addr_o),
  .par_o     (par_o),
  .src_sel   (src_sel),
  .strb_lvl  (strb_lvl),
  .strb_rise (strb_rise),
  .cap_fire  (cap_fire)
);

// File: tb/rt_addr_capture_bench.sv
`timescale 1ns/1ps
module rt_addr_capture_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_pin_i = '0;
  logic        par_pin_i = 1'b0;
  logic        strobe_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [4:0]  addr_o;
  logic        par_o, resp_ok_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rt_addr_capture u_rt_addr_capture (.*);

  task automatic check(input string req, input logic [5:0] exp);
    logic exp_ok;
    exp_ok = ($countones(exp) % 2) == 1;
    n_chk++;
    if ({addr_o, par_o, resp_ok_o} !== {exp, exp_ok}) begin
      n_bad++;
      $display("FAIL %s: got addr=%0d par=%0b ok=%0b, exp addr=%0d par=%0b ok=%0b",
               req, addr_o, par_o, resp_ok_o, exp[5:1], exp[0], exp_ok);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic host_wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  initial begin
    logic [5:0] held;
    // R1/R9: strobe tied high through reset, no capture after reset
    addr_pin_i = 5'd21; par_pin_i = 1'b0;
    ticks(3);
    check("R1 reset value", 6'b000001);
    rst_ni = 1'b1;
    ticks(6);
    check("R9 strobe high at reset, no capture", 6'b000001);

    // R2/R8: transparent sweep of every pin pattern
    strobe_i = 1'b0;
    ticks(4);
    for (int v = 0; v < 64; v++) begin
      {addr_pin_i, par_pin_i} = 6'(v);
      ticks(2);
      check("R2/R8 transparent", 6'(v));
    end

    // R3: rising strobe edge captures, later pin changes ignored
    {addr_pin_i, par_pin_i} = 6'b101100;
    ticks(3);
    strobe_i = 1'b1;
    ticks(6);
    check("R3 edge capture", 6'b101100);
    for (int v = 0; v < 8; v++) begin
      {addr_pin_i, par_pin_i} = 6'(v * 7 + 1);
      ticks(2);
      check("R3 hold while strobe high", 6'b101100);
    end
    held = 6'b101100;

    // R5: each incomplete enable combination, capture write ignored
    for (int m = 0; m < 3; m++) begin
      host_wr(3'd3, (m & 1) ? 16'h8000 : 16'h7FFF);
      host_wr(3'd4, (m & 2) ? 16'h0008 : 16'hFFF7);
      {addr_pin_i, par_pin_i} = 6'(m + 40);
      host_wr(3'd5, 16'h003F);
      ticks(1);
      check("R5 capture write without both enables", held);
    end

    // R4/R7: full sequence, pin source: data bits don't care
    host_wr(3'd3, 16'h8000);
    host_wr(3'd4, 16'h0008);
    for (int v = 0; v < 16; v++) begin
      {addr_pin_i, par_pin_i} = 6'(v * 3 + 5);
      host_wr(3'd5, 16'(63 - v * 3));
      {addr_pin_i, par_pin_i} = 6'(v * 3 + 6);
      ticks(1);
      check("R4/R7 host capture of pins", 6'(v * 3 + 5));
    end

    // R6: host source, all 64 data patterns, pins varying
    host_wr(3'd6, 16'h0020);
    for (int v = 0; v < 64; v++) begin
      {addr_pin_i, par_pin_i} = ~6'(v);
      host_wr(3'd5, 16'hFFC0 | 16'(v));
      ticks(1);
      check("R6 host source load", 6'(v));
    end
    held = 6'd63;

    // R6: pins and strobe have no effect with host source
    strobe_i = 1'b0;
    {addr_pin_i, par_pin_i} = 6'b010101;
    ticks(5);
    check("R6 strobe low ignored", held);
    strobe_i = 1'b1;
    ticks(5);
    check("R6 strobe edge ignored", held);

    // R5: with host source, disarm then write
    host_wr(3'd4, 16'h0000);
    host_wr(3'd5, 16'h0012);
    ticks(1);
    check("R5 disarmed host write", held);

    // R1: reset again restores default and pin source
    rst_ni = 1'b0;
    ticks(2);
    check("R1 reset value again", 6'b000001);
    rst_ni = 1'b1;
    strobe_i = 1'b0;
    {addr_pin_i, par_pin_i} = 6'b110011;
    ticks(6);
    check("R1 pin source after reset", 6'b110011);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule